// File: doc/BRIEF.md
# Interrupt Source Layer

This block holds the per-source state for a small group of interrupt inputs and turns their activity into offers to a downstream presentation unit. Each source is built at elaboration as either level-sensitive or message-signalled, and keeps a target server number, an 8-bit priority and a saved priority. A priority of 0xff masks the source. Each offer carries the global source number, the server, the priority and the saved priority. The global number is the local index plus a base offset.

The presentation unit answers with three kinds of event. A reject, given as a global number, means the offer was not taken. An EOI, also given as a global number, means service has finished. A resend asks every source to look at itself again. Level sources track the input level and a sent flag. Message sources track a rejected flag and a masked-pending flag. One configuration port writes the server, the priority and the saved priority of one source. When one event creates several offers, they wait in a pending set and leave one per cycle over a valid/ready handshake.

Top module: `irq_source_layer`

## Requirements
- R1: After reset, no offer is valid, every priority and saved priority is 0xff, and all status flags are clear. Reset does not change the level/message type of a source. In the default build, sources 8 to 15 are level and sources 0 to 7 are message.
- R2: A message source whose priority is not 0xff is offered when its input is high for a cycle. Every offer shows offNum = BASE + index (default BASE 4096), with the server, priority and saved priority from the last configuration write to that source. An offer becomes valid in the cycle after the event that caused it.
- R3: A message source that fires while its priority is 0xff records masked-pending and makes no offer. A resend does not release it. A later configuration write with a priority other than 0xff clears masked-pending and offers the source once.
- R4: A level source copies its input into its asserted flag. On an input change, a configuration write or a resend, it is offered if it is unmasked, asserted and not sent, and the offer sets sent. While sent is set, toggling the input gives no new offer.
- R5: A configuration write that unmasks a level source whose input is high and which is not sent offers that source.
- R6: A reject of a message source sets its rejected flag. A resend clears the flag and offers the source again if it is unmasked. If it is masked, the offer is dropped and the flag stays clear.
- R7: A reject of a level source clears its sent flag and makes no offer by itself. The next resend offers it again if its input is still high.
- R8: An EOI clears the sent flag of a level source. An EOI has no effect on a message source.
- R9: Reject and EOI numbers below BASE or at or above BASE + NUM_SRC change no state, including numbers whose low bits alias a local index.
- R10: At most one offer leaves per cycle. While offValid is high and offReady is low, the same source number is held. Otherwise the lowest pending index goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | NUM_SRC | Source inputs: a level for level sources, a one-cycle high for each message |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | IDX_W | Local index to configure |
| cfgServer | input | SRV_W | Target server number to store |
| cfgPrio | input | 8 | Priority to store (0xff masks) |
| cfgSaved | input | 8 | Saved priority to store |
| rejValid | input | 1 | Reject event strobe |
| rejNum | input | NUM_W | Global number of the rejected source |
| eoiValid | input | 1 | EOI event strobe |
| eoiNum | input | NUM_W | Global number of the finished source |
| resendReq | input | 1 | Resend strobe: all sources re-examine themselves |
| offValid | output | 1 | An offer is presented |
| offReady | input | 1 | The presentation unit takes the offer |
| offNum | output | NUM_W | Global source number of the offer |
| offServer | output | SRV_W | Target server of the offer |
| offPrio | output | 8 | Priority of the offer |
| offSaved | output | 8 | Saved priority of the offered source |

## Verification
A wrong flag stays hidden until an event reads it. A sent flag stuck high shows up as a missing offer on the next resend. A lost rejected or masked-pending flag shows up as a missing offer on the resend or unmasking write that should have released it. A flag that was wrongly set shows up as an extra offer one cycle after that event. The bench therefore follows each reject, EOI and mask change with the event that makes its effect visible at the offer port, and compares that port with a reference model on every cycle.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  // per-source event strobes from control to datapath
  typedef struct packed {
    logic cfgHit;
    logic rejHit;
    logic eoiHit;
    logic resend;
    logic issued;
  } srcStrobe_t;
endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_W = 16,
  parameter int BASE = 4096,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             rejValid,
  input  logic [NUM_W-1:0] rejNum,
  input  logic             eoiValid,
  input  logic [NUM_W-1:0] eoiNum,
  input  logic             resendReq,
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic             offReady,
  output logic             offValid,
  output logic [IDX_W-1:0] grantIdx,
  output srcStrobe_t       strobes [NUM_SRC]
);
  localparam logic [NUM_W:0] LO_NUM = (NUM_W+1)'(BASE);
  localparam logic [NUM_W:0] HI_NUM = (NUM_W+1)'(BASE + NUM_SRC);

  logic rejIn, eoiIn;
  logic [IDX_W-1:0] rejLocal, eoiLocal, freeIdx, heldIdx;
  logic holdValid;

  // global-to-local decode; numbers outside the window are dropped
  assign rejIn = rejValid && ({1'b0, rejNum} >= LO_NUM) && ({1'b0, rejNum} < HI_NUM);
  assign eoiIn = eoiValid && ({1'b0, eoiNum} >= LO_NUM) && ({1'b0, eoiNum} < HI_NUM);
  assign rejLocal = IDX_W'(rejNum - NUM_W'(BASE));
  assign eoiLocal = IDX_W'(eoiNum - NUM_W'(BASE));

  // lowest pending index wins unless a stalled grant is held
  always_comb begin
    freeIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pendVec[i]) freeIdx = IDX_W'(i);
  end

  assign grantIdx = holdValid ? heldIdx : freeIdx;
  assign offValid = |pendVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      heldIdx   <= '0;
    end else begin
      holdValid <= offValid && !offReady;
      heldIdx   <= grantIdx;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_strobe
    assign strobes[i].cfgHit = cfgWe && (cfgIdx == IDX_W'(i));
    assign strobes[i].rejHit = rejIn && (rejLocal == IDX_W'(i));
    assign strobes[i].eoiHit = eoiIn && (eoiLocal == IDX_W'(i));
    assign strobes[i].resend = resendReq;
    assign strobes[i].issued = offValid && offReady && (grantIdx == IDX_W'(i));
  end
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SRV_W = 4,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'hFF00,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [PRIO_W-1:0]  cfgSaved,
  input  srcStrobe_t         strobes [NUM_SRC],
  input  logic [IDX_W-1:0]   grantIdx,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] sentVec,
  output logic [NUM_SRC-1:0] rejVec,
  output logic [SRV_W-1:0]   grantServer,
  output logic [PRIO_W-1:0]  grantPrio,
  output logic [PRIO_W-1:0]  grantSaved
);
  logic [SRV_W-1:0]  serverArr [NUM_SRC];
  logic [PRIO_W-1:0] prioArr   [NUM_SRC];
  logic [PRIO_W-1:0] savedArr  [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PRIO_W-1:0] prioQ, savedQ, prioNext;
    logic [SRV_W-1:0]  serverQ;
    logic pendQ, open, offerNow;

    assign prioNext = strobes[i].cfgHit ? cfgPrio : prioQ;
    assign open = (prioNext != PRIO_MASKED);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioQ   <= PRIO_MASKED;
        savedQ  <= PRIO_MASKED;
        serverQ <= '0;
      end else if (strobes[i].cfgHit) begin
        prioQ   <= cfgPrio;
        savedQ  <= cfgSaved;
        serverQ <= cfgServer;
      end
    end

    if (LEVEL_MAP[i]) begin : g_level
      logic assertQ, sentQ, sentKeep, recheck;
      assign sentKeep = sentQ && !strobes[i].rejHit && !strobes[i].eoiHit;
      assign recheck  = (irqIn[i] != assertQ) || strobes[i].cfgHit || strobes[i].resend;
      assign offerNow = recheck && open && irqIn[i] && !sentKeep;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          assertQ <= 1'b0;
          sentQ   <= 1'b0;
        end else begin
          assertQ <= irqIn[i];
          sentQ   <= sentKeep || offerNow;
        end
      end
      assign sentVec[i] = sentQ;
      assign rejVec[i]  = 1'b0;
    end else begin : g_msg
      logic rejQ, mpendQ;
      assign offerNow = open && (irqIn[i] || (strobes[i].cfgHit && mpendQ)
                                 || (strobes[i].resend && rejQ));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rejQ   <= 1'b0;
          mpendQ <= 1'b0;
        end else begin
          rejQ   <= (rejQ && !strobes[i].resend) || strobes[i].rejHit;
          mpendQ <= (mpendQ || (irqIn[i] && !open)) && !(strobes[i].cfgHit && open);
        end
      end
      assign sentVec[i] = 1'b0;
      assign rejVec[i]  = rejQ;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ <= 1'b0;
      else       pendQ <= (pendQ && !strobes[i].issued) || offerNow;
    end

    assign pendVec[i]   = pendQ;
    assign serverArr[i] = serverQ;
    assign prioArr[i]   = prioQ;
    assign savedArr[i]  = savedQ;
  end

  assign grantServer = serverArr[grantIdx];
  assign grantPrio   = prioArr[grantIdx];
  assign grantSaved  = savedArr[grantIdx];
endmodule

// File: rtl/irq_source_layer.sv
module irq_source_layer
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_W = 16,
  parameter int SRV_W = 4,
  parameter int BASE = 4096,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'hFF00,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [SRV_W-1:0]   cfgServer,
  input  logic [PRIO_W-1:0]  cfgPrio,
  input  logic [PRIO_W-1:0]  cfgSaved,
  input  logic               rejValid,
  input  logic [NUM_W-1:0]   rejNum,
  input  logic               eoiValid,
  input  logic [NUM_W-1:0]   eoiNum,
  input  logic               resendReq,
  output logic               offValid,
  input  logic               offReady,
  output logic [NUM_W-1:0]   offNum,
  output logic [SRV_W-1:0]   offServer,
  output logic [PRIO_W-1:0]  offPrio,
  output logic [PRIO_W-1:0]  offSaved
);
  srcStrobe_t strobes [NUM_SRC];
  logic [NUM_SRC-1:0] pendVec, sentVec, rejVec;
  logic [IDX_W-1:0] grantIdx;

  irq_src_ctrl #(.NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .pendVec(pendVec), .offReady(offReady),
    .offValid(offValid), .grantIdx(grantIdx), .strobes(strobes)
  );

  irq_src_state #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .LEVEL_MAP(LEVEL_MAP)) u_state (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgServer(cfgServer),
    .cfgPrio(cfgPrio), .cfgSaved(cfgSaved), .strobes(strobes), .grantIdx(grantIdx),
    .pendVec(pendVec), .sentVec(sentVec), .rejVec(rejVec),
    .grantServer(offServer), .grantPrio(offPrio), .grantSaved(offSaved)
  );

  assign offNum = NUM_W'(BASE) + NUM_W'(grantIdx);
endmodule

// File: rtl/irq_source_layer_chk.sv
module irq_source_layer_chk
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_W = 16,
  parameter int BASE = 4096,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'hFF00
) (
  input logic               clk,
  input logic               rstN,
  input logic               offValid,
  input logic               offReady,
  input logic [NUM_W-1:0]   offNum,
  input logic [NUM_SRC-1:0] sentVec,
  input logic [NUM_SRC-1:0] rejVec,
  input srcStrobe_t         strobes [NUM_SRC]
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !offValid);

  assert_num_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    offValid |-> (32'(offNum) >= BASE) && (32'(offNum) < BASE + NUM_SRC));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    offValid && !offReady |=> offValid && $stable(offNum));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    if (LEVEL_MAP[i]) begin : g_lvl
      assert_sent_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
        sentVec[i] && !strobes[i].rejHit && !strobes[i].eoiHit |=> sentVec[i]);
    end else begin : g_msg
      assert_reject_marks_R6: assert property (@(posedge clk) disable iff (!rstN)
        strobes[i].rejHit |=> rejVec[i]);
    end
  end
endmodule

bind irq_source_layer irq_source_layer_chk #(
  .NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .BASE(BASE), .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk(clk), .rstN(rstN), .offValid(offValid), .offReady(offReady),
  .offNum(offNum), .sentVec(sentVec), .rejVec(rejVec), .strobes(strobes)
);

// File: tb/sim_irq_source_layer.sv
`timescale 1ns/1ps
module sim_irq_source_layer;
  localparam int NS = 16;
  localparam int NW = 16;
  localparam int SW = 4;
  localparam int BASE = 4096;
  localparam logic [NS-1:0] LMAP = 16'hFF00;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic [NS-1:0] irqIn = '0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgIdx = '0;
  logic [SW-1:0] cfgServer = '0;
  logic [7:0] cfgPrio = '0, cfgSaved = '0;
  logic rejValid = 1'b0, eoiValid = 1'b0, resendReq = 1'b0;
  logic [NW-1:0] rejNum = '0, eoiNum = '0;
  logic offReady = 1'b1;
  logic offValid;
  logic [NW-1:0] offNum;
  logic [SW-1:0] offServer;
  logic [7:0] offPrio, offSaved;

  irq_source_layer #(.NUM_SRC(NS), .NUM_W(NW), .SRV_W(SW), .BASE(BASE), .LEVEL_MAP(LMAP)) u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgServer(cfgServer), .cfgPrio(cfgPrio), .cfgSaved(cfgSaved),
    .rejValid(rejValid), .rejNum(rejNum), .eoiValid(eoiValid), .eoiNum(eoiNum),
    .resendReq(resendReq), .offValid(offValid), .offReady(offReady),
    .offNum(offNum), .offServer(offServer), .offPrio(offPrio), .offSaved(offSaved)
  );

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  // behavioural reference model
  int mPrio [NS];
  int mSaved [NS];
  int mServer [NS];
  bit mAsserted [NS];
  bit mSent [NS];
  bit mRej [NS];
  bit mMaskPend [NS];
  bit mWant [NS];
  int mLock = -1;
  int g;
  bit cfgI, rejI, eoiI, evt;

  function automatic int modelGrant();
    if (mLock >= 0) return mLock;
    for (int i = 0; i < NS; i++) if (mWant[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) begin
        mPrio[i] = 255; mSaved[i] = 255; mServer[i] = 0;
        mAsserted[i] = 0; mSent[i] = 0; mRej[i] = 0; mMaskPend[i] = 0; mWant[i] = 0;
      end
      mLock = -1;
    end else begin
      g = modelGrant();
      if (g >= 0 && offReady) mWant[g] = 0;
      mLock = (g >= 0 && !offReady) ? g : -1;
      for (int i = 0; i < NS; i++) begin
        cfgI = cfgWe && (int'(cfgIdx) == i);
        rejI = rejValid && (int'(rejNum) == BASE + i);
        eoiI = eoiValid && (int'(eoiNum) == BASE + i);
        if (cfgI) begin
          mPrio[i] = int'(cfgPrio); mSaved[i] = int'(cfgSaved); mServer[i] = int'(cfgServer);
        end
        if (LMAP[i]) begin
          evt = cfgI || resendReq || (irqIn[i] != mAsserted[i]);
          if (rejI || eoiI) mSent[i] = 0;
          mAsserted[i] = irqIn[i];
          if (evt && mPrio[i] != 255 && mAsserted[i] && !mSent[i]) begin
            mSent[i] = 1; mWant[i] = 1;
          end
        end else begin
          if (cfgI && mMaskPend[i] && mPrio[i] != 255) begin
            mMaskPend[i] = 0; mWant[i] = 1;
          end
          if (irqIn[i]) begin
            if (mPrio[i] == 255) mMaskPend[i] = 1;
            else mWant[i] = 1;
          end
          if (resendReq && mRej[i]) begin
            mRej[i] = 0;
            if (mPrio[i] != 255) mWant[i] = 1;
          end
          if (rejI) mRej[i] = 1;
        end
      end
    end
  end

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int eg;
      eg = modelGrant();
      checks++;
      if ((eg >= 0) !== offValid ||
          (eg >= 0 && (int'(offNum) != BASE + eg || int'(offServer) != mServer[eg] ||
                       int'(offPrio) != mPrio[eg] || int'(offSaved) != mSaved[eg]))) begin
        errors++;
        $display("FAIL %s model: valid=%0b num=%0h srv=%0d prio=%0h expected valid=%0b num=%0h",
                 curReq, offValid, offNum, offServer, offPrio, (eg >= 0), BASE + eg);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectOffer(input string req, input bit v, input int idx);
    checks++;
    if (offValid !== v || (v && int'(offNum) != BASE + idx)) begin
      errors++;
      $display("FAIL %s: offValid=%0b offNum=%0h expected offValid=%0b offNum=%0h",
               req, offValid, offNum, v, BASE + idx);
    end
  endtask

  task automatic doCfg(input int idx, input int srv, input int prio, input int saved);
    cfgWe = 1; cfgIdx = 4'(idx); cfgServer = SW'(srv); cfgPrio = 8'(prio); cfgSaved = 8'(saved);
    cyc();
    cfgWe = 0;
  endtask

  task automatic pulseMsg(input int idx);
    irqIn[idx] = 1'b1;
    cyc();
    irqIn[idx] = 1'b0;
  endtask

  task automatic doRej(input int num);
    rejValid = 1; rejNum = NW'(num);
    cyc();
    rejValid = 0;
  endtask

  task automatic doEoi(input int num);
    eoiValid = 1; eoiNum = NW'(num);
    cyc();
    eoiValid = 0;
  endtask

  task automatic doResend();
    resendReq = 1;
    cyc();
    resendReq = 0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10: run state=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc();
    curReq = "R1";
    expectOffer("R1", 0, 0);

    // R3: masked message sets masked-pending, unmask releases it
    curReq = "R3";
    pulseMsg(0);
    expectOffer("R3", 0, 0);
    doResend();
    expectOffer("R3", 0, 0);
    doCfg(0, 3, 5, 7);
    expectOffer("R3", 1, 0);
    checks++;
    if (offServer !== 4'd3 || offPrio !== 8'd5 || offSaved !== 8'd7) begin
      errors++;
      $display("FAIL R2: srv=%0d prio=%0h saved=%0h expected srv=3 prio=5 saved=7",
               offServer, offPrio, offSaved);
    end
    cyc();
    expectOffer("R3", 0, 0);

    // R2: unmasked message fires
    curReq = "R2";
    doCfg(1, 1, 2, 2);
    expectOffer("R2", 0, 0);
    pulseMsg(1);
    expectOffer("R2", 1, 1);
    cyc();
    expectOffer("R2", 0, 0);

    // R10: stall holds grant, then lowest index first
    curReq = "R10";
    offReady = 0;
    doCfg(2, 0, 4, 4);
    doCfg(3, 0, 4, 4);
    irqIn[2] = 1; irqIn[3] = 1;
    cyc();
    irqIn[2] = 0; irqIn[3] = 0;
    expectOffer("R10", 1, 2);
    cyc();
    expectOffer("R10", 1, 2);
    pulseMsg(1);
    expectOffer("R10", 1, 2);
    offReady = 1;
    cyc();
    expectOffer("R10", 1, 1);
    cyc();
    expectOffer("R10", 1, 3);
    cyc();
    expectOffer("R10", 0, 0);

    // R6: message reject and resend
    curReq = "R6";
    doRej(BASE + 1);
    expectOffer("R6", 0, 0);
    doResend();
    expectOffer("R6", 1, 1);
    cyc();
    doRej(BASE + 1);
    doCfg(1, 1, 255, 2);
    doResend();
    expectOffer("R6", 0, 0);
    doCfg(1, 1, 2, 2);
    expectOffer("R6", 0, 0);
    doResend();
    expectOffer("R6", 0, 0);

    // R4: level offer and sent flag
    curReq = "R4";
    doCfg(8, 2, 3, 3);
    expectOffer("R4", 0, 0);
    irqIn[8] = 1;
    cyc();
    expectOffer("R4", 1, 8);
    repeat (3) cyc();
    expectOffer("R4", 0, 0);
    irqIn[8] = 0;
    cyc();
    irqIn[8] = 1;
    cyc();
    expectOffer("R4", 0, 0);

    // R7: level reject then resend
    curReq = "R7";
    doRej(BASE + 8);
    expectOffer("R7", 0, 0);
    doResend();
    expectOffer("R7", 1, 8);
    cyc();

    // R8: EOI on level and on message
    curReq = "R8";
    doEoi(BASE + 8);
    expectOffer("R8", 0, 0);
    doResend();
    expectOffer("R8", 1, 8);
    cyc();
    doEoi(BASE + 0);
    doResend();
    expectOffer("R8", 0, 0);

    // R9: out-of-window numbers are ignored
    curReq = "R9";
    doEoi(8);
    doResend();
    expectOffer("R9", 0, 0);
    doRej(BASE + NS);
    doRej(BASE - 1);
    doResend();
    expectOffer("R9", 0, 0);

    // R5: unmasking an asserted level source
    curReq = "R5";
    irqIn[9] = 1;
    cyc();
    expectOffer("R5", 0, 0);
    doCfg(9, 1, 1, 1);
    expectOffer("R5", 1, 9);
    cyc();

    // R1: reset mid-run restores masks and clears status
    curReq = "R1";
    rstN = 0;
    cyc();
    expectOffer("R1", 0, 0);
    rstN = 1;
    cyc();
    expectOffer("R1", 0, 0);
    pulseMsg(0);
    expectOffer("R1", 0, 0);
    curReq = "R5";
    doCfg(8, 2, 6, 6);
    expectOffer("R5", 1, 8);
    cyc();
    expectOffer("R5", 0, 0);

    finishRun();
  end
endmodule